// File: doc/BRIEF.md
# Parity-Checked Serial Pixel Receiver

This block takes a single serial data line, clocked by a bit-rate clock supplied from outside, and rebuilds parallel pixel words from it. Every 30 bit times carry one frame. A frame holds a two-bit start marker, 24 pixel bits, three control bits (horizontal sync, vertical sync, data enable) and an odd parity bit. The receiver first finds frame alignment by sliding a 30-bit window one bit at a time until it sees the marker. It then confirms the alignment on the next frame. From then on it checks the parity of each frame and places the 27 payload bits on a parallel bus. It also produces a recreated pixel clock at one thirtieth of the bit rate.

A frame that fails the parity check is discarded. The previous word stays on the bus for one more pixel period, and an error flag is raised for that period. Loss of the input clock, reported as a level input, and every power mode except active force all outputs into a fixed idle pattern and clear the frame alignment. The receiver must find alignment again before it delivers data.

Top module: `pixel_deser`

## Requirements
- R1: The first line bit of a frame is the marker bit 1, followed by the marker bit 0. Next come 27 payload bits sent most significant first: payload bit 26 is horizontal sync, bit 25 vertical sync, bit 24 data enable, and bits 23..0 are the pixel with bit 23 first. The frame ends with a parity bit, chosen so that the payload and parity bits together hold an odd number of ones.
- R2: Out of reset or idle, the outputs stay idle until the marker has been seen at two positions exactly 30 bits apart. The second of these two frames is the first word delivered.
- R3: A frame with a correct marker and correct parity appears on the pixel, sync and enable outputs at the clock edge that samples its parity bit. The words never change at a rising edge of the pixel clock.
- R4: While aligned, the pixel clock is low for the first 15 bit cycles after each frame edge and high for the next 15.
- R5: A frame with a parity error leaves the previous word on the outputs and raises the error output for the 30 bit cycles up to the next frame edge. The next good frame clears the flag and updates the word.
- R6: While aligned, a frame whose first two bits are not 1 then 0 drops alignment, and the outputs go idle at the edge that samples its last bit.
- R7: When the clock-present input is sampled low, the outputs are idle after that same clock edge and alignment is cleared. Frames sent while it is low have no effect. After it returns, two aligned frames are needed again (R2).
- R8: The power-mode input encodes 2'b10 as active, 2'b01 as standby and 2'b00 as shutdown. Code 2'b11 is treated as shutdown. Any mode other than active behaves like a missing clock (R7): outputs idle after one edge, frames ignored, and the receiver must align again on return to active.
- R9: The idle pattern is pixel clock low, data enable low, error flag low, and horizontal sync, vertical sync and all pixel bits high.
- R10: While the asynchronous active-low reset is held, the outputs show the idle pattern.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data, sampled on the rising edge |
| clkPresent | input | 1 | High while the serial source clock is present |
| pwrMode | input | 2 | Power mode: 10 active, 01 standby, 00/11 shutdown |
| pixOut | output | 24 | Pixel bits |
| hsOut | output | 1 | Horizontal sync |
| vsOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pclkOut | output | 1 | Recreated pixel clock |
| parErrOut | output | 1 | High for one pixel period after a rejected frame |

## Verification
A bit counter that slips out of phase with the line shows up within one frame at the ports. The marker check at the next frame edge fails, and the outputs drop to the idle pattern 30 bit cycles later at most. An alignment state machine stuck in a wrong state shows either as idle outputs after two good frames, or as a running pixel clock and a changing bus while the receiver should be unaligned. Either is visible at the edge where the second frame completes. A parity evaluation that is wrong in either direction shows at the frame edge itself, as a bus that changes when it should hold or an error flag with the wrong level. A lost-clock or power-mode input that is not honoured shows at the very next edge, as outputs that are not idle.

// File: rtl/pixel_deser_pkg.sv
package pixel_deser_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_STBY = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSVD = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'b00,
    ST_CONFIRM = 2'b01,
    ST_LOCKED  = 2'b10
  } align_st_e;

  // Strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic forceIdle;  // outputs take the idle pattern
    logic frameTick;  // an aligned frame completes at this edge
    logic pclkHigh;   // level of the pixel clock after this edge
  } ctl_strobe_t;

endpackage

// File: rtl/pixel_deser_ctrl.sv
module pixel_deser_ctrl
  import pixel_deser_pkg::*;
#(
  parameter int FRAME_BITS = 30
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkPresent,
  input  logic [1:0]  pwrMode,
  input  logic        markerOk,
  output ctl_strobe_t strobe
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int HALF  = FRAME_BITS / 2;

  align_st_e        state, stateNext;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic             run;
  logic             frameEnd;

  assign run      = clkPresent && (pwr_mode_e'(pwrMode) == MODE_RUN);
  assign frameEnd = (state != ST_HUNT) && (bitCnt == CNT_W'(FRAME_BITS - 1));

  always_comb begin
    stateNext = state;
    nextCnt   = bitCnt + CNT_W'(1);
    if (!run) begin
      stateNext = ST_HUNT;
      nextCnt   = '0;
    end else begin
      case (state)
        ST_HUNT: begin
          nextCnt = '0;
          if (markerOk) stateNext = ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (frameEnd) begin
            nextCnt   = '0;
            stateNext = markerOk ? ST_LOCKED : ST_HUNT;
          end
        end
        ST_LOCKED: begin
          if (frameEnd) begin
            nextCnt = '0;
            if (!markerOk) stateNext = ST_HUNT;
          end
        end
        default: begin
          stateNext = ST_HUNT;
          nextCnt   = '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.forceIdle = (stateNext != ST_LOCKED);
    strobe.frameTick = run && frameEnd && markerOk;
    strobe.pclkHigh  = (nextCnt >= CNT_W'(HALF));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= nextCnt;
    end
  end

endmodule

// File: rtl/pixel_deser_dp.sv
module pixel_deser_dp
  import pixel_deser_pkg::*;
#(
  parameter int PIX_BITS  = 24,
  parameter int CTRL_BITS = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serIn,
  input  ctl_strobe_t                   strobe,
  output logic                          markerOk,
  output logic [PIX_BITS+CTRL_BITS-1:0] wordOut,
  output logic                          pclkOut,
  output logic                          parErrOut
);

  localparam int PAY   = PIX_BITS + CTRL_BITS;
  localparam int FRAME = PAY + 3;
  // Data enable is the lowest control bit; everything else idles high
  localparam logic [PAY-1:0] IDLE_WORD = ~(PAY'(1) << PIX_BITS);

  logic [FRAME-2:0] shiftReg;
  logic [FRAME-1:0] window;
  logic [PAY-1:0]   payload;
  logic             parityOk;

  // Window holds the frame as it would be if the current bit were its last
  assign window   = {shiftReg, serIn};
  assign markerOk = (window[FRAME-1 -: 2] == 2'b10);
  assign payload  = window[PAY:1];
  assign parityOk = ^window[PAY:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= window[FRAME-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= IDLE_WORD;
      pclkOut   <= 1'b0;
      parErrOut <= 1'b0;
    end else if (strobe.forceIdle) begin
      wordOut   <= IDLE_WORD;
      pclkOut   <= 1'b0;
      parErrOut <= 1'b0;
    end else begin
      pclkOut <= strobe.pclkHigh;
      if (strobe.frameTick) begin
        parErrOut <= !parityOk;
        if (parityOk) wordOut <= payload;
      end
    end
  end

endmodule

// File: rtl/pixel_deser.sv
module pixel_deser
  import pixel_deser_pkg::*;
#(
  parameter int PIX_BITS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serIn,
  input  logic                clkPresent,
  input  logic [1:0]          pwrMode,
  output logic [PIX_BITS-1:0] pixOut,
  output logic                hsOut,
  output logic                vsOut,
  output logic                deOut,
  output logic                pclkOut,
  output logic                parErrOut
);

  localparam int CTRL_BITS  = 3;
  localparam int PAY        = PIX_BITS + CTRL_BITS;
  localparam int FRAME_BITS = PAY + 3;

  ctl_strobe_t    strobe;
  logic           markerOk;
  logic [PAY-1:0] word;

  pixel_deser_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkPresent (clkPresent),
    .pwrMode    (pwrMode),
    .markerOk   (markerOk),
    .strobe     (strobe)
  );

  pixel_deser_dp #(.PIX_BITS(PIX_BITS), .CTRL_BITS(CTRL_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .strobe    (strobe),
    .markerOk  (markerOk),
    .wordOut   (word),
    .pclkOut   (pclkOut),
    .parErrOut (parErrOut)
  );

  assign pixOut = word[PIX_BITS-1:0];
  assign deOut  = word[PIX_BITS];
  assign vsOut  = word[PIX_BITS+1];
  assign hsOut  = word[PIX_BITS+2];

endmodule

// File: rtl/pixel_deser_chk.sv
module pixel_deser_chk #(
  parameter int PIX_BITS = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                clkPresent,
  input logic [1:0]          pwrMode,
  input logic [PIX_BITS-1:0] pixOut,
  input logic                hsOut,
  input logic                vsOut,
  input logic                deOut,
  input logic                pclkOut,
  input logic                parErrOut
);

  localparam int FRAME_BITS = PIX_BITS + 6;
  localparam int HALF       = FRAME_BITS / 2;

  logic       idleNow;
  logic [7:0] highRun;

  assign idleNow = !pclkOut && !deOut && !parErrOut && hsOut && vsOut && (&pixOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             highRun <= '0;
    else if (!pclkOut)     highRun <= '0;
    else if (highRun != '1) highRun <= highRun + 8'd1;
  end

  // R7: missing clock forces idle after one edge
  a_r7_clock_loss_idle: assert property (@(posedge clk) disable iff (!rstN)
    !clkPresent |=> idleNow);

  // R8: non-active modes force idle after one edge
  a_r8_mode_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode != 2'b10) |=> idleNow);

  // R5: a rejected frame leaves the word unchanged
  a_r5_hold_on_error: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErrOut) |-> ($stable(pixOut) && $stable({hsOut, vsOut, deOut})));

  // R3: words never change on a rising pixel clock
  a_r3_stable_at_pclk_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pclkOut) |-> ($stable(pixOut) && $stable({hsOut, vsOut, deOut})));

  // R4: pixel clock high phase is at most half a frame
  a_r4_pclk_high_len: assert property (@(posedge clk) disable iff (!rstN)
    pclkOut |-> (highRun < 8'(HALF)));

endmodule

bind pixel_deser pixel_deser_chk #(.PIX_BITS(PIX_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkPresent (clkPresent),
  .pwrMode    (pwrMode),
  .pixOut     (pixOut),
  .hsOut      (hsOut),
  .vsOut      (vsOut),
  .deOut      (deOut),
  .pclkOut    (pclkOut),
  .parErrOut  (parErrOut)
);

// File: tb/tb_pixel_deser.sv
`timescale 1ns/1ps
module tb_pixel_deser;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0;
  logic        clkPresent = 1'b1;
  logic [1:0]  pwrMode = 2'b10;
  logic [23:0] pixOut;
  logic        hsOut, vsOut, deOut, pclkOut, parErrOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  localparam logic [26:0] IDLE_WORD = {2'b11, 1'b0, 24'hFFFFFF};

  always #2.5 clk = ~clk;

  pixel_deser dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .clkPresent(clkPresent),
    .pwrMode(pwrMode), .pixOut(pixOut), .hsOut(hsOut), .vsOut(vsOut),
    .deOut(deOut), .pclkOut(pclkOut), .parErrOut(parErrOut)
  );

  function automatic logic [26:0] outWord();
    return {hsOut, vsOut, deOut, pixOut};
  endfunction

  // R1 frame layout: index 29 goes out first
  function automatic logic [29:0] mkFrame(logic [26:0] pay, bit badPar, bit badMark);
    logic par;
    par = (~^pay) ^ badPar;
    return {(badMark ? 2'b00 : 2'b10), pay, par};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive each bit at a negedge; returns at the negedge after the last bit was sampled
  task automatic sendFrame(logic [29:0] f, output int highs);
    highs = 0;
    for (int i = 29; i >= 0; i--) begin
      serIn = f[i];
      @(negedge clk);
      if (pclkOut) highs++;
    end
  endtask

  task automatic sendZeros(int n);
    for (int i = 0; i < n; i++) begin
      serIn = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic checkIdle(string req);
    check(outWord() == IDLE_WORD && !pclkOut && !parErrOut, req,
          32'({pclkOut, parErrOut, outWord()}), 32'({2'b00, IDLE_WORD}));
  endtask

  task automatic checkWord(logic [26:0] exp, string req);
    check(outWord() == exp && !parErrOut, req,
          32'({parErrOut, outWord()}), 32'({1'b0, exp}));
  endtask

  // Bring the receiver to lock from any state (R2 relock path)
  task automatic relock(logic [26:0] a, logic [26:0] b, string req);
    int h;
    sendZeros(60);
    sendFrame(mkFrame(a, 0, 0), h);
    checkIdle({req, " idle after one aligned frame"});
    sendFrame(mkFrame(b, 0, 0), h);
    checkWord(b, {req, " second aligned frame delivered"});
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    checkIdle("R10 reset idle pattern (R9)");
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_lock();
    int h;
    sendZeros(7);
    checkIdle("R2 idle while hunting");
    sendFrame(mkFrame(27'h2ABCDEF, 0, 0), h);
    checkIdle("R2 idle after first aligned frame");
    sendFrame(mkFrame(27'h1234567, 0, 0), h);
    checkWord(27'h1234567, "R2 second frame delivered");
  endtask

  task automatic t_stream();
    logic [26:0] pats [4] = '{27'h5A5A5A5, 27'h0000000, 27'h7FFFFFF, 27'h4C0FFEE};
    int h;
    foreach (pats[k]) begin
      sendFrame(mkFrame(pats[k], 0, 0), h);
      checkWord(pats[k], "R1 R3 payload on outputs at frame edge");
      check(h == 15, "R4 pixel clock high count", 32'(h), 32'd15);
    end
    check(hsOut == 1'b1 && vsOut == 1'b0 && deOut == 1'b0 && pixOut == 24'hC0FFEE,
          "R1 field positions", 32'({hsOut, vsOut, deOut}), 32'h4);
  endtask

  task automatic t_parity();
    int h;
    sendFrame(mkFrame(27'h0F0F0F0, 0, 0), h);
    checkWord(27'h0F0F0F0, "R5 good frame before error");
    sendFrame(mkFrame(27'h1111111, 1, 0), h);
    check(outWord() == 27'h0F0F0F0 && parErrOut, "R5 bad parity held word and flag",
          32'({parErrOut, outWord()}), 32'({1'b1, 27'h0F0F0F0}));
    sendFrame(mkFrame(27'h2222222, 1, 0), h);
    check(outWord() == 27'h0F0F0F0 && parErrOut, "R5 second bad frame held",
          32'({parErrOut, outWord()}), 32'({1'b1, 27'h0F0F0F0}));
    check(h == 15, "R4 pixel clock keeps running on error", 32'(h), 32'd15);
    sendFrame(mkFrame(27'h3333333, 0, 0), h);
    checkWord(27'h3333333, "R5 good frame clears flag");
  endtask

  task automatic t_marker();
    int h;
    sendFrame(mkFrame(27'h6543210, 0, 1), h);
    checkIdle("R6 missing marker drops alignment");
    relock(27'h0ABCDEF, 27'h1FEDCBA, "R6");
  endtask

  task automatic t_clkloss();
    int h;
    logic [29:0] f;
    f = mkFrame(27'h7777777, 0, 0);
    for (int i = 29; i >= 20; i--) begin
      serIn = f[i];
      @(negedge clk);
    end
    clkPresent = 1'b0;
    @(negedge clk);
    checkIdle("R7 idle one edge after clock loss");
    sendFrame(mkFrame(27'h1234567, 0, 0), h);
    sendFrame(mkFrame(27'h1234568, 0, 0), h);
    checkIdle("R7 frames ignored without clock");
    clkPresent = 1'b1;
    relock(27'h2468ACE, 27'h13579BD, "R7");
  endtask

  task automatic t_modes();
    logic [1:0] modes [3] = '{2'b01, 2'b00, 2'b11};
    int h;
    foreach (modes[k]) begin
      pwrMode = modes[k];
      @(negedge clk);
      checkIdle("R8 non-active mode idles after one edge");
      sendFrame(mkFrame(27'h5555555, 0, 0), h);
      sendFrame(mkFrame(27'h2AAAAAA, 0, 0), h);
      checkIdle("R8 frames ignored in non-active mode");
      pwrMode = 2'b10;
      relock(27'h0C0C0C0 + 27'(k), 27'h3030303 + 27'(k), "R8");
    end
  endtask

  initial begin
    t_reset();
    t_lock();
    t_stream();
    t_parity();
    t_marker();
    t_clkloss();
    t_modes();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule